// File: doc/BRIEF.md
# Sound Channel Length Timer with Extra Clocking

This block counts down the remaining play time of one sound channel. Software loads a 6-bit length field L, which sets the counter to 64 − L. A control byte carries a length-enable bit and a trigger bit. A 256 Hz length tick, issued by an external frame sequencer on its even steps, decrements the counter while length is enabled. When the counter reaches zero, the block emits a one-cycle expire pulse that the channel uses to silence itself.

The block also models the counter behaviour that depends on the phase of the frame sequencer. The sequencer supplies a window flag that is high while its next step will not clock length. During that window, two events cost one extra count at once. The first is a write that turns length-enable on. The second is a trigger with length enabled that leaves the counter at its full value. While the channel's unit is powered off, the length field can still be written, but the enable bit cannot be set.

Top module: `len_timer`

## Requirements
- R1: After reset the counter is 0, the expire output is 0 and the control read-back is 0xBF.
- R2: A length write of field L loads the counter with 64 − L in the following cycle, whether or not the unit is powered.
- R3: A length tick decrements the counter only while length is enabled and the counter is nonzero. A decrement that reaches zero raises expire for exactly one cycle. Otherwise the counter holds.
- R4: A control write with the trigger bit (bit 7) set reloads the counter to 64 if it is zero, and leaves a nonzero counter unchanged.
- R5: A control write that changes length-enable (bit 6) from 0 to 1 while the window flag is high and the counter is nonzero decrements the counter at once. If that reaches zero, expire is raised. With the flag low, or with enable already 1, no extra decrement occurs.
- R6: A triggering write that leaves length-enable at 1 while the window flag is high, and finds the counter at 64 after the reload step, sets the counter to 63.
- R7: Within one control write, the extra decrement from the enable edge is applied before the trigger reload. Expire is raised only if the final counter is zero.
- R8: A register write (length or control) in the same cycle as a length tick takes priority, and the tick is dropped.
- R9: The control read-back returns the length-enable bit on bit 6 and 1 on every other bit.
- R10: While the power input is low, length-enable is held at 0, control writes and ticks are ignored, and the counter clears in the cycle power is removed unless a length write loads it in that cycle.
- R11: When a length write and a control write occur in the same cycle, the control write acts on the newly loaded value.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| pwr_on | input | 1 | Unit powered; low forces the powered-off behaviour |
| len_wr | input | 1 | Length field write strobe |
| len_val | input | 6 | Length field L |
| ctl_wr | input | 1 | Control byte write strobe |
| ctl_data | input | 8 | Control byte: bit 7 trigger, bit 6 length-enable |
| len_tick | input | 1 | 256 Hz length clock, one cycle wide |
| extra_win | input | 1 | High while the next sequencer step will not clock length |
| count | output | 7 | Current counter value, 0 to 64 |
| expire | output | 1 | One-cycle pulse when a decrement reaches zero |
| ctl_rdata | output | 8 | Control byte read-back |

## Verification
A wrong counter shows on `count` one cycle after the write or tick that produced it. A wrong enable register shows on `ctl_rdata` bit 6 in the same way. It also shows as a decrement that is missing or extra on the next tick. Ordering faults between the enable-edge decrement and the trigger reload only show in specific starting states: a counter of 0, 1 or 64, combined with an enable edge, a trigger and the window flag. The sweep covers every combination of those inputs, so such a fault appears as a wrong count or a wrong expire value right after that write. A failure to clear at power-off shows on `count` one cycle after power falls.

// File: rtl/len_timer_pkg.sv
package len_timer_pkg;
   typedef struct packed {
      logic trig;
      logic en;
   } lt_cmd_t;
endpackage

// File: rtl/lt_enable_reg.sv
module lt_enable_reg #(
   parameter int DATA_W = 8,
   parameter int EN_BIT = 6
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              ctl_wr,
   input  logic              wr_en_bit,
   output logic              en_q,
   output logic              en_next,
   output logic              en_rise,
   output logic [DATA_W-1:0] rdata
);
   localparam logic [DATA_W-1:0] EN_MASK = DATA_W'(1) << EN_BIT;

   always_comb begin
      if (!pwr_on)     en_next = 1'b0;
      else if (ctl_wr) en_next = wr_en_bit;
      else             en_next = en_q;
   end

   assign en_rise = pwr_on && ctl_wr && wr_en_bit && !en_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q <= 1'b0;
      else        en_q <= en_next;
   end

   assign rdata = ~EN_MASK | (en_q ? EN_MASK : '0);

   // R10: enable cannot survive a powered-off cycle
   a_r10_off_clears_en: assert property (@(posedge clk) disable iff (!rst_n)
      !pwr_on |=> !en_q);
   // R9: read-back follows the enable register
   a_r9_readback_bit: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && ctl_wr) |=> (rdata[EN_BIT] == $past(wr_en_bit)));
endmodule

// File: rtl/lt_count_next.sv
module lt_count_next #(
   parameter int LEN_W     = 6,
   parameter bit EXTRA_CLK = 1'b1,
   localparam int CNT_W    = LEN_W + 1
) (
   input  logic [CNT_W-1:0] cnt_q,
   input  logic             pwr_on,
   input  logic             pwr_fall,
   input  logic             len_wr,
   input  logic [LEN_W-1:0] len_val,
   input  logic             ctl_wr,
   input  logic             trig,
   input  logic             en_q,
   input  logic             en_next,
   input  logic             en_rise,
   input  logic             win,
   input  logic             tick,
   output logic [CNT_W-1:0] cnt_d,
   output logic             hit_zero
);
   localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LEN_W;

   logic win_eff;
   generate
      if (EXTRA_CLK) begin : g_extra
         assign win_eff = win;
      end else begin : g_plain
         assign win_eff = 1'b0;
      end
   endgenerate

   logic [CNT_W-1:0] base;
   logic             dec_hit;

   always_comb begin
      // length load first; power-off clear only when no load
      if (len_wr)        base = FULL - {1'b0, len_val};
      else if (pwr_fall) base = '0;
      else               base = cnt_q;

      cnt_d   = base;
      dec_hit = 1'b0;
      if (ctl_wr && pwr_on) begin
         // enable edge first, then trigger reload, then full-value trim
         if (en_rise && win_eff && cnt_d != '0) begin
            cnt_d   = cnt_d - 1'b1;
            dec_hit = (cnt_d == '0);
         end
         if (trig && cnt_d == '0) cnt_d = FULL;
         if (trig && en_next && win_eff && cnt_d == FULL) cnt_d = FULL - 1'b1;
      end else if (!len_wr && pwr_on && tick && en_q && cnt_d != '0) begin
         cnt_d   = cnt_d - 1'b1;
         dec_hit = (cnt_d == '0);
      end
      hit_zero = dec_hit && (cnt_d == '0);
   end
endmodule

// File: rtl/len_timer.sv
module len_timer #(
   parameter int LEN_W     = 6,
   parameter int DATA_W    = 8,
   parameter int EN_BIT    = 6,
   parameter int TRIG_BIT  = 7,
   parameter bit EXTRA_CLK = 1'b1,
   localparam int CNT_W    = LEN_W + 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              pwr_on,
   input  logic              len_wr,
   input  logic [LEN_W-1:0]  len_val,
   input  logic              ctl_wr,
   input  logic [DATA_W-1:0] ctl_data,
   input  logic              len_tick,
   input  logic              extra_win,
   output logic [CNT_W-1:0]  count,
   output logic              expire,
   output logic [DATA_W-1:0] ctl_rdata
);
   import len_timer_pkg::*;

   localparam logic [CNT_W-1:0] FULL = CNT_W'(1) << LEN_W;

   generate
      if (LEN_W < 1 || LEN_W > 16) begin : g_bad_len
         $error("len_timer: LEN_W out of range");
      end
      if (EN_BIT >= DATA_W || TRIG_BIT >= DATA_W || EN_BIT == TRIG_BIT) begin : g_bad_bits
         $error("len_timer: control bit positions invalid");
      end
   endgenerate

   lt_cmd_t          cmd;
   logic             en_q, en_next, en_rise;
   logic             pwr_q, pwr_fall;
   logic [CNT_W-1:0] cnt_q, cnt_d;
   logic             hit_zero;
   logic             exp_q;

   assign cmd.trig = ctl_data[TRIG_BIT];
   assign cmd.en   = ctl_data[EN_BIT];

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pwr_q <= 1'b0;
      else        pwr_q <= pwr_on;
   end
   assign pwr_fall = pwr_q && !pwr_on;

   lt_enable_reg #(.DATA_W(DATA_W), .EN_BIT(EN_BIT)) u_en (
      .clk       (clk),
      .rst_n     (rst_n),
      .pwr_on    (pwr_on),
      .ctl_wr    (ctl_wr),
      .wr_en_bit (cmd.en),
      .en_q      (en_q),
      .en_next   (en_next),
      .en_rise   (en_rise),
      .rdata     (ctl_rdata)
   );

   lt_count_next #(.LEN_W(LEN_W), .EXTRA_CLK(EXTRA_CLK)) u_next (
      .cnt_q    (cnt_q),
      .pwr_on   (pwr_on),
      .pwr_fall (pwr_fall),
      .len_wr   (len_wr),
      .len_val  (len_val),
      .ctl_wr   (ctl_wr),
      .trig     (cmd.trig),
      .en_q     (en_q),
      .en_next  (en_next),
      .en_rise  (en_rise),
      .win      (extra_win),
      .tick     (len_tick),
      .cnt_d    (cnt_d),
      .hit_zero (hit_zero)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         cnt_q <= '0;
         exp_q <= 1'b0;
      end else begin
         cnt_q <= cnt_d;
         exp_q <= hit_zero;
      end
   end

   assign count  = cnt_q;
   assign expire = exp_q;

   // R2: counter never exceeds the full value
   a_r2_range: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= FULL);
   // R2: a lone length write loads 64 - L
   a_r2_load: assert property (@(posedge clk) disable iff (!rst_n)
      (len_wr && !(ctl_wr && pwr_on)) |=> (cnt_q == FULL - {1'b0, $past(len_val)}));
   // R3: an enabled tick on a nonzero counter takes exactly one count
   a_r3_tick_dec: assert property (@(posedge clk) disable iff (!rst_n)
      (pwr_on && len_tick && !len_wr && !ctl_wr && en_q && cnt_q != '0)
      |=> (cnt_q == $past(cnt_q) - 1'b1));
   // R3: expire only with an empty counter
   a_r3_expire_zero: assert property (@(posedge clk) disable iff (!rst_n)
      expire |-> (cnt_q == '0));
   // R3: expire is a single-cycle pulse while nothing is written
   a_r3_expire_pulse: assert property (@(posedge clk) disable iff (!rst_n)
      (expire && !ctl_wr) |=> !expire);

   generate
      if (EXTRA_CLK) begin : g_chk_extra
         // R6: a trigger in the window with length enabled never leaves a full counter
         a_r6_trim_full: assert property (@(posedge clk) disable iff (!rst_n)
            (pwr_on && ctl_wr && cmd.trig && cmd.en && extra_win) |=> (cnt_q != FULL));
      end
   endgenerate
endmodule

// File: tb/len_timer_tb.sv
module len_timer_tb;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       pwr_on = 1'b1;
   logic       len_wr = 1'b0;
   logic [5:0] len_val = '0;
   logic       ctl_wr = 1'b0;
   logic [7:0] ctl_data = '0;
   logic       len_tick = 1'b0;
   logic       extra_win = 1'b0;
   logic [6:0] count;
   logic       expire;
   logic [7:0] ctl_rdata;

   int checks = 0;
   int fails  = 0;

   always #2 clk = ~clk;

   len_timer u_dut (
      .clk(clk), .rst_n(rst_n), .pwr_on(pwr_on), .len_wr(len_wr), .len_val(len_val),
      .ctl_wr(ctl_wr), .ctl_data(ctl_data), .len_tick(len_tick), .extra_win(extra_win),
      .count(count), .expire(expire), .ctl_rdata(ctl_rdata)
   );

   task automatic chk(input string req, input int act, input int exp);
      checks++;
      if (act != exp) begin
         fails++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   // one cycle of stimulus, driven and released on falling edges
   task automatic step(input bit lw, input int lv, input bit cw, input bit en,
                       input bit tr, input bit tk, input bit w);
      len_wr    = lw;
      len_val   = 6'(lv);
      ctl_wr    = cw;
      ctl_data  = {tr, en, 6'b0};
      len_tick  = tk;
      extra_win = w;
      @(negedge clk);
      len_wr = 1'b0; ctl_wr = 1'b0; len_tick = 1'b0; extra_win = 1'b0;
   endtask

   task automatic setup(input int c, input bit oe);
      step(0, 0, 1, 1, 0, 0, 0);
      if (c == 0) begin
         step(1, 63, 0, 0, 0, 0, 0);
         step(0, 0, 0, 0, 0, 1, 0);
      end else begin
         step(1, 64 - c, 0, 0, 0, 0, 0);
      end
      step(0, 0, 1, oe, 0, 0, 0);
   endtask

   initial begin
      #400000;
      fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end

   initial begin
      int cvals [6] = '{0, 1, 2, 5, 63, 64};
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);
      // R1 reset state
      chk("R1 count", count, 0);
      chk("R1 expire", expire, 0);
      chk("R1 rdata", ctl_rdata, 8'hBF);

      // R2 all length fields
      for (int l = 0; l < 64; l++) begin
         step(1, l, 0, 0, 0, 0, 0);
         chk("R2 load", count, 64 - l);
      end

      // R9 read-back
      step(0, 0, 1, 1, 0, 0, 0);
      chk("R9 en=1", ctl_rdata, 8'hFF);
      step(0, 0, 1, 0, 0, 0, 0);
      chk("R9 en=0", ctl_rdata, 8'hBF);

      // R3 tick drain with enable on
      step(0, 0, 1, 1, 0, 0, 0);
      step(1, 61, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R3 tick 3->2", count, 2);
      chk("R3 no expire", expire, 0);
      step(0, 0, 0, 0, 0, 1, 0);
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R3 tick to 0", count, 0);
      chk("R3 expire", expire, 1);
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R3 hold at 0", count, 0);
      chk("R3 expire once", expire, 0);
      // R3 tick ignored with enable off
      step(0, 0, 1, 0, 0, 0, 0);
      step(1, 61, 0, 0, 0, 0, 0);
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R3 disabled hold", count, 3);

      // R4 R5 R6 R7 sweep of starting value and control write
      foreach (cvals[i]) begin
         for (int m = 0; m < 16; m++) begin
            bit oe, ne, tr, w;
            int v, x;
            oe = m[0]; ne = m[1]; tr = m[2]; w = m[3];
            setup(cvals[i], oe);
            v = cvals[i]; x = 0;
            if (!oe && ne && w && v != 0) begin v--; x = (v == 0); end
            if (tr && v == 0) v = 64;
            if (tr && ne && w && v == 64) v = 63;
            if (v != 0) x = 0;
            step(0, 0, 1, ne, tr, 0, w);
            chk("R4/R5/R6/R7 count", count, v);
            chk("R5/R7 expire", expire, x);
         end
      end

      // R8 write wins over tick
      step(0, 0, 1, 1, 0, 0, 0);
      step(1, 54, 0, 0, 0, 0, 0);
      step(0, 0, 1, 1, 0, 1, 0);
      chk("R8 ctl over tick", count, 10);
      step(1, 40, 0, 0, 0, 1, 0);
      chk("R8 len over tick", count, 24);

      // R11 load then control on the loaded value
      setup(5, 0);
      step(1, 63, 1, 1, 0, 0, 1);
      chk("R11 count", count, 0);
      chk("R11 expire", expire, 1);

      // R10 power off
      step(0, 0, 1, 1, 0, 0, 0);
      step(1, 30, 0, 0, 0, 0, 0);
      pwr_on = 1'b0;
      @(negedge clk);
      chk("R10 cleared", count, 0);
      chk("R10 en off", ctl_rdata, 8'hBF);
      step(0, 0, 1, 1, 1, 0, 0);
      chk("R10 ctl ignored rd", ctl_rdata, 8'hBF);
      chk("R10 ctl ignored cnt", count, 0);
      step(1, 60, 0, 0, 0, 0, 0);
      chk("R10 load while off", count, 4);
      step(0, 0, 0, 0, 0, 1, 0);
      chk("R10 tick ignored", count, 4);
      pwr_on = 1'b1;
      @(negedge clk);
      chk("R10 power back cnt", count, 4);
      chk("R10 power back rd", ctl_rdata, 8'hBF);

      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
   end
endmodule